// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Split Registers

This block is a serial port that sits on a simple valid/ready memory bus inside one 4 KB I/O page. Software sends a byte by storing it to the transmit register. It takes a received byte by loading the receive register, and that load also removes the byte from a small receive queue. A separate status word tells software whether the transmitter is still busy and whether any received bytes are waiting. There is no shared data register: transmit, receive and status each have their own word offset.

The serial line carries 8 data bits, least significant bit first, framed by one low start bit and one high stop bit, with no parity. The bit period is derived at elaboration time from the clock frequency and the baud rate. At 50 MHz and 115200 baud it comes to 434 clocks. The receiver synchronises the incoming line and waits for a falling edge. It confirms the start bit half a bit later, then samples every following bit in the middle of its period.

Every bus access to the page completes in the cycle it is presented, and read data is returned combinationally in that cycle. The reset input is active-low. It is asserted asynchronously and must be released synchronously to the clock.

Top module: `mmio_uart_port`

## Requirements
- R1: A write accepted at offset 0x0 while the transmitter is idle starts a frame from the next cycle. The line carries a low start bit, then wdata[7:0] least significant bit first, then a high stop bit. Each bit lasts CPB clocks, where CPB = round(CLK_HZ / BAUD). Bits 31:8 of the write data are ignored.
- R2: tx_busy is 1 from the cycle after the write is accepted until 10*CPB cycles later. A write to offset 0x0 while tx_busy is 1 has no effect on the line.
- R3: The receiver needs a high-to-low transition of the synchronised line. It rejects a low pulse that has ended by the half-bit check. A good frame is pushed into the receive queue 3 + CPB/2 + 9*CPB clock edges after the first edge that sees the start bit.
- R4: A frame whose stop bit samples low is discarded and never enters the queue.
- R5: A read of offset 0x4 returns the oldest queued byte in bits 7:0, with zeros above, and removes that byte in the same access. With the queue empty the read returns 0 and changes nothing.
- R6: A byte that completes while the queue holds FIFO_DEPTH bytes is dropped, and the queued bytes keep their order.
- R7: A read of offset 0x8 returns tx_busy in bit 0 and "queue not empty" in bit 1, with all other bits 0.
- R8: bus_ready equals bus_valid when bus_addr[31:12] equals 0x10000, and is 0 otherwise, in the same cycle. Accesses outside the page have no effect and read 0. Reads of offset 0x0 and of unmapped offsets return 0. Writes to any offset other than 0x0 have no effect.
- R9: While reset is asserted, and after it is released, tx is 1, tx_busy is 0 and the receive queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Access accepted this cycle (page hit) |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data; bits 7:0 used |
| bus_rdata | output | 32 | Read data, valid in the accepting cycle |
| tx | output | 1 | Serial output, idle high |
| rx | input | 1 | Serial input, idle high |

## Verification
The hardest situation to reach from the ports is a byte completing its stop bit while the receive queue is already full. This has to happen while earlier bytes stay untouched and readable in order afterwards. The stimulus gets there by driving the serial input bit by bit with complete frames, back to back, one more than the queue depth, without any intervening reads, and only then draining the queue. The same line driver produces a stop bit held low and a short low glitch. A reference model predicts, cycle by cycle, the line level, the queue contents and every read value.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam int unsigned SP_DATA_BITS  = 8;
  localparam int unsigned SP_FRAME_BITS = SP_DATA_BITS + 2;

  localparam int unsigned SP_OFF_TXD  = 'h0;
  localparam int unsigned SP_OFF_RXD  = 'h4;
  localparam int unsigned SP_OFF_STAT = 'h8;

  localparam int unsigned SP_STAT_TXBUSY = 0;
  localparam int unsigned SP_STAT_RXVLD  = 1;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  function automatic int unsigned sp_clks_per_bit(input int unsigned clk_hz,
                                                  input int unsigned baud);
    return (clk_hz + baud / 2) / baud;
  endfunction

endpackage

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int unsigned CPB = 434
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [sp_pkg::SP_DATA_BITS-1:0] din,
  output logic                          tx,
  output logic                          busy
);
  import sp_pkg::*;

  localparam int unsigned CW = $clog2(CPB + 1);
  localparam int unsigned FB = SP_FRAME_BITS;
  localparam int unsigned IW = $clog2(FB);

  logic          busy_q, busy_d;
  logic [FB-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          bit_end;
  logic          upd_en;

  assign bit_end = (cnt_q == CW'(CPB - 1));
  assign upd_en  = busy_q || load;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    if (!busy_q) begin
      if (load) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, din, 1'b0};
        cnt_d  = '0;
        idx_d  = '0;
      end
    end else if (bit_end) begin
      cnt_d = '0;
      sh_d  = {1'b1, sh_q[FB-1:1]};
      if (idx_q == IW'(FB - 1)) begin
        busy_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
    end
  end

  assign tx   = sh_q[0];
  assign busy = busy_q;

endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
  parameter int unsigned CPB = 434
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rx,
  output logic                            push,
  output logic [sp_pkg::SP_DATA_BITS-1:0] data
);
  import sp_pkg::*;

  localparam int unsigned CW   = $clog2(CPB + 1);
  localparam int unsigned HALF = (CPB / 2 > 0) ? CPB / 2 : 1;
  localparam int unsigned DW   = SP_DATA_BITS;
  localparam int unsigned IW   = $clog2(DW);

  logic          s1_q, s2_q, prev_q;
  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          bit_end;
  logic          fsm_en;

  assign bit_end = (cnt_q == CW'(CPB - 1));
  assign fsm_en  = (state_q != RX_IDLE) || (prev_q && !s2_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    push    = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (prev_q && !s2_q) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
      end
      RX_START: begin
        if (cnt_q == CW'(HALF - 1)) begin
          cnt_d   = '0;
          idx_d   = '0;
          state_d = s2_q ? RX_IDLE : RX_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (bit_end) begin
          cnt_d = '0;
          sh_d  = {s2_q, sh_q[DW-1:1]};
          if (idx_q == IW'(DW - 1)) begin
            state_d = RX_STOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (bit_end) begin
          cnt_d   = '0;
          state_d = RX_IDLE;
          push    = s2_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= rx;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
    end else if (fsm_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
    end
  end

  assign data = sh_q;

endmodule

// File: rtl/sp_fifo.sv
module sp_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [CNTW-1:0]  count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = do_push ? ptr_inc(wr_q) : wr_q;
    rd_d  = do_pop  ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (do_push || do_pop) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (do_push && (wr_q == AW'(i))) begin
        mem[i] <= din;
      end
    end
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;

endmodule

// File: rtl/mmio_uart_port.sv
module mmio_uart_port #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned BAUD       = 115_200,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter logic [31:0] BASE_ADDR  = 32'h1000_0000,
  parameter int unsigned PAGE_BITS  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  output logic        bus_ready,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx,
  input  logic        rx
);
  import sp_pkg::*;

  localparam int unsigned CPB  = sp_clks_per_bit(CLK_HZ, BAUD);
  localparam int unsigned DW   = SP_DATA_BITS;
  localparam int unsigned CNTW = $clog2(FIFO_DEPTH + 1);

  logic                 page_hit, acc;
  logic [PAGE_BITS-1:0] offset;
  logic                 sel_txd, sel_rxd, sel_stat;
  logic                 wr_go, rd_rx_req, fifo_pop;
  logic                 tx_busy;
  logic                 rx_push;
  logic [DW-1:0]        rx_byte, fifo_head;
  logic                 fifo_empty, fifo_full;
  logic [CNTW-1:0]      fifo_count;
  logic                 wdata_unused;

  assign page_hit = (bus_addr[31:PAGE_BITS] == BASE_ADDR[31:PAGE_BITS]);
  assign offset   = bus_addr[PAGE_BITS-1:0];
  assign acc      = bus_valid && page_hit;
  assign bus_ready = acc;

  assign sel_txd  = (offset == PAGE_BITS'(SP_OFF_TXD));
  assign sel_rxd  = (offset == PAGE_BITS'(SP_OFF_RXD));
  assign sel_stat = (offset == PAGE_BITS'(SP_OFF_STAT));

  assign wr_go     = acc && bus_we && sel_txd && !tx_busy;
  assign rd_rx_req = acc && !bus_we && sel_rxd;
  assign fifo_pop  = rd_rx_req && !fifo_empty;

  assign wdata_unused = ^bus_wdata[31:DW];

  always_comb begin
    bus_rdata = '0;
    if (acc && !bus_we) begin
      if (sel_rxd && !fifo_empty) begin
        bus_rdata[DW-1:0] = fifo_head;
      end else if (sel_stat) begin
        bus_rdata[SP_STAT_TXBUSY] = tx_busy;
        bus_rdata[SP_STAT_RXVLD]  = !fifo_empty;
      end
    end
  end

  sp_tx #(.CPB(CPB)) tx_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wr_go),
    .din  (bus_wdata[DW-1:0]),
    .tx   (tx),
    .busy (tx_busy)
  );

  sp_rx #(.CPB(CPB)) rx_i (
    .clk  (clk),
    .rst_n(rst_n),
    .rx   (rx),
    .push (rx_push),
    .data (rx_byte)
  );

  sp_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DW)) fifo_i (
    .clk  (clk),
    .rst_n(rst_n),
    .push (rx_push),
    .din  (rx_byte),
    .pop  (fifo_pop),
    .dout (fifo_head),
    .empty(fifo_empty),
    .full (fifo_full),
    .count(fifo_count)
  );

endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx,
  input logic            tx_busy,
  input logic            wr_go,
  input logic            rd_rx_req,
  input logic            fifo_empty,
  input logic [31:0]     bus_rdata,
  input logic            rx_push,
  input logic            fifo_full,
  input logic            fifo_pop,
  input logic [CNTW-1:0] fifo_count
);

  AST_LOAD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> tx_busy); // R2

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx); // R1

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx); // R9

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx_req && fifo_empty) |-> (bus_rdata == 32'd0)); // R5

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && fifo_full && !fifo_pop) |=> (fifo_count == $past(fifo_count))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNTW'(DEPTH)); // R6

endmodule

bind mmio_uart_port sp_checker #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx        (tx),
  .tx_busy   (tx_busy),
  .wr_go     (wr_go),
  .rd_rx_req (rd_rx_req),
  .fifo_empty(fifo_empty),
  .bus_rdata (bus_rdata),
  .rx_push   (rx_push),
  .fifo_full (fifo_full),
  .fifo_pop  (fifo_pop),
  .fifo_count(fifo_count)
);

// File: tb/mmio_uart_port_tb_top.sv
`timescale 1ns/1ps
module mmio_uart_port_tb_top;

  localparam int CLK_HZ = 1_843_200;
  localparam int BAUD   = 115_200;
  localparam int CPB    = 16;
  localparam int HALF   = CPB / 2;
  localparam int DEPTH  = 4;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_ready;
  logic        bus_we;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tx;
  logic        rx;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_tag = "R8";

  // reference model state
  int        cyc = 0;
  bit        m_busy = 0;
  int        m_t = 0;
  logic [9:0] m_frame = '1;
  logic [7:0] q[$];
  int        pend_due[$];
  logic [7:0] pend_byte[$];

  mmio_uart_port #(
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIFO_DEPTH(DEPTH)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx(tx), .rx(rx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit hit(input logic [31:0] a);
    return a[31:12] == 20'h10000;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [31:0] a);
    logic [31:0] r;
    r = '0;
    if (hit(a)) begin
      case (a[11:0])
        12'h004: if (q.size() > 0) r = {24'd0, q[0]};
        12'h008: r = {30'd0, q.size() > 0, m_busy};
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  // behavioural model, advanced on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_frame = '1;
      q.delete(); pend_due.delete(); pend_byte.delete();
    end else begin
      bit full_before;
      cyc++;
      if (m_busy) begin
        m_t++;
        if (m_t == 10 * CPB) m_busy = 0;
      end else if (bus_valid && bus_we && hit(bus_addr) && bus_addr[11:0] == 12'h000) begin
        m_busy = 1; m_t = 0; m_frame = {1'b1, bus_wdata[7:0], 1'b0};
      end
      full_before = (q.size() == DEPTH);
      if (bus_valid && !bus_we && hit(bus_addr) && bus_addr[11:0] == 12'h004 && q.size() > 0)
        void'(q.pop_front());
      if (pend_due.size() > 0 && pend_due[0] == cyc) begin
        if (!full_before) q.push_back(pend_byte[0]);
        void'(pend_due.pop_front());
        void'(pend_byte.pop_front());
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (!finished) begin
      logic exp_tx;
      exp_tx = m_busy ? m_frame[m_t / CPB] : 1'b1;
      check(m_busy ? "R1" : "R9", {31'd0, tx}, {31'd0, exp_tx});
      check("R8", {31'd0, bus_ready}, {31'd0, bus_valid && hit(bus_addr)});
      if (bus_valid && !bus_we) check(cur_tag, bus_rdata, exp_rdata(bus_addr));
    end
  end

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    cur_tag = tag;
    bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [31:0] a, input string tag);
    @(negedge clk);
    cur_tag = tag;
    bus_valid = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic send_frame(input logic [7:0] b, input bit good_stop);
    @(negedge clk);
    rx = 0;
    if (good_stop) begin
      pend_due.push_back(cyc + 3 + HALF + 9 * CPB);
      pend_byte.push_back(b);
    end
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx = good_stop;
    repeat (CPB) @(negedge clk);
    rx = 1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [31:0] A_TXD  = 32'h1000_0000;
  localparam logic [31:0] A_RXD  = 32'h1000_0004;
  localparam logic [31:0] A_STAT = 32'h1000_0008;

  initial begin
    rst_n = 0; rx = 1; bus_valid = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    wait_cycles(3);
    rst_n = 1;
    wait_cycles(2);

    // R9: state after reset
    bus_read(A_STAT, "R9");
    // R5: empty pop returns zero
    bus_read(A_RXD, "R5");

    // R1: first frame, R2: status busy and ignored write
    bus_write(A_TXD, 32'h0000_00A5, "R1");
    wait_cycles(5);
    bus_read(A_STAT, "R2");
    bus_write(A_TXD, 32'h0000_003C, "R2");
    wait_cycles(10 * CPB);
    bus_read(A_STAT, "R7");

    // R1: upper write bits ignored
    bus_write(A_TXD, 32'hFFFF_FF5A, "R1");
    wait_cycles(10 * CPB + 4);

    // R3: two good frames, status, ordered pops
    send_frame(8'h5A, 1);
    send_frame(8'h81, 1);
    bus_read(A_STAT, "R7");
    bus_read(A_RXD, "R3");
    bus_read(A_RXD, "R5");
    bus_read(A_RXD, "R5");

    // R4: bad stop bit discarded
    send_frame(8'h77, 0);
    bus_read(A_STAT, "R4");

    // R3: short glitch rejected
    @(negedge clk); rx = 0;
    wait_cycles(3); rx = 1;
    wait_cycles(2 * CPB);
    bus_read(A_STAT, "R3");

    // R6: overflow drops the newest byte
    send_frame(8'h11, 1);
    send_frame(8'h22, 1);
    send_frame(8'h33, 1);
    send_frame(8'h44, 1);
    send_frame(8'h55, 1);
    bus_read(A_STAT, "R6");
    for (int i = 0; i < DEPTH + 1; i++) bus_read(A_RXD, "R6");

    // R8: decode, out-of-page and unmapped offsets
    send_frame(8'hE7, 1);
    bus_write(32'h2000_0000, 32'h0000_0000, "R8");
    bus_read(32'h1000_1004, "R8");
    bus_read(32'h1000_000C, "R8");
    bus_read(A_TXD, "R8");
    bus_write(A_RXD, 32'h0000_0012, "R8");
    bus_write(A_STAT, 32'h0000_0003, "R8");
    bus_read(A_STAT, "R8");
    bus_read(A_RXD, "R8");

    // R1/R3 concurrent traffic
    fork
      send_frame(8'hC3, 1);
      bus_write(A_TXD, 32'h0000_0096, "R1");
    join
    bus_read(A_RXD, "R3");
    wait_cycles(10 * CPB);

    // R9: reset in the middle of activity
    send_frame(8'h3E, 1);
    bus_write(A_TXD, 32'h0000_00F0, "R9");
    wait_cycles(2 * CPB);
    @(negedge clk); rst_n = 0;
    wait_cycles(3);
    rst_n = 1;
    wait_cycles(2);
    bus_read(A_STAT, "R9");
    bus_read(A_RXD, "R9");
    wait_cycles(4);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule